// File: doc/BRIEF.md
# Approximate binary logarithm encoder

This block turns an unsigned integer word into a log-like code of the same width. It looks for the highest set bit in the upper band of the word. It stores a biased form of that bit's position in a small exponent field at the top of the code. Below that field it packs the bits that follow the leading one, left-aligned, with the leading one itself left implied. The result keeps most of the precision of the input while squeezing its dynamic range, which makes it a useful index for later table-based arithmetic.

Words whose highest set bit lies below the exponent's reach are coded as subnormal. These get exponent zero, and the low band of the input is moved up so that its top bit lands at the top of the fraction field. Nothing is removed in this case. Each input carries a valid strobe. A new word may be offered on every clock. Each result comes out exactly two clocks after its input, with its own valid strobe.

Top module: `binlog_enc`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly two clock edges later, and a new word is accepted on every edge whether or not the previous cycle was valid.
- R2: While `rst` is sampled high, and on the cycle after it, `out_valid` is low whatever `in_valid` carries.
- R3: With the defaults (32-bit word, 4-bit exponent), a leading one at bit p, for p from 17 to 31, gives an exponent field `out_code[31:28]` equal to p − 16. In general the field is p − (DATA_W − 2^EXP_W), so the top bit always codes as 2^EXP_W − 1.
- R4: For such a word, `out_code[27:0]` holds the input bits below p. Bit p−1 sits at bit 27, then the rest follow in order. Bit p itself is dropped, bits that fall below bit 0 are discarded, and unused low positions are zero.
- R5: When no bit from 31 to 17 is set, the exponent field is 0 and `out_code[27:0]` equals input bits 16..0 shifted left by 11. Input bit 16 lands at bit 27.
- R6: An input of zero gives an output code of zero, with `out_valid` asserted as for any other word.
- R7: Input 0x0700_0000 gives 0xAC00_0000, and input 0x0000_8000 gives 0x0400_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a word to encode |
| in_data | input | DATA_W | Unsigned input word |
| out_valid | output | 1 | Marks `out_code` as a result |
| out_code | output | DATA_W | Exponent field on top, fraction field below |

## Verification
The bench builds two instances. The first uses the default 32-bit word with a 4-bit exponent. The second uses a 12-bit word with a 3-bit exponent, giving a 9-bit fraction and a normal band of bits 11..5. The small instance is swept over every one of its 4096 inputs. That covers every leading-one position and every subnormal value, including the cases where the bits below the leading one exceed the fraction and must be cut off. The default instance is driven with the two worked values, zero, walking single ones, descending runs of ones and scrambled words. Bubbles in `in_valid` run through both instances so that R1 is checked against gaps as well as back-to-back traffic.

// File: rtl/binlog_pkg.sv
package binlog_pkg;

  // Lowest bit position that still gets a nonzero exponent code.
  function automatic int norm_floor(input int data_w, input int exp_w);
    return data_w - ((1 << exp_w) - 1);
  endfunction

  // Width of a shift amount able to hold values up to max_shift.
  function automatic int shift_bits(input int max_shift);
    return (max_shift < 2) ? 1 : $clog2(max_shift + 1);
  endfunction

endpackage

// File: rtl/binlog_lead_detect.sv
module binlog_lead_detect #(
  parameter int DATA_W  = 32,
  parameter int MIN_POS = 17,
  parameter int POS_W   = $clog2(DATA_W),
  localparam int BAND   = DATA_W - MIN_POS
) (
  input  logic [DATA_W-1:0] word,
  output logic              found,
  output logic [POS_W-1:0]  pos,
  output logic [BAND-1:0]   first
);

  // above[k]: some bit at position MIN_POS+k or higher is set
  logic [BAND:0] above;
  assign above[BAND] = 1'b0;

  for (genvar k = 0; k < BAND; k++) begin : g_band
    assign above[k] = above[k+1] | word[MIN_POS+k];
    assign first[k] = word[MIN_POS+k] & ~above[k+1];
  end

  assign found = above[0];

  // Encode the one-hot leading position; default is the band floor,
  // which is what the subnormal path shifts against.
  always_comb begin
    pos = POS_W'(MIN_POS);
    for (int k = 0; k < BAND; k++) begin
      if (first[k]) pos = POS_W'(MIN_POS + k);
    end
  end

endmodule

// File: rtl/binlog_shifter.sv
module binlog_shifter #(
  parameter int W     = 32,
  parameter int SH_W  = 4,
  parameter int OUT_W = 28
) (
  input  logic [W-1:0]     din,
  input  logic [SH_W-1:0]  amt,
  output logic [OUT_W-1:0] dout
);

  logic [W-1:0] stage [SH_W+1];
  assign stage[0] = din;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    assign stage[i+1] = amt[i] ? (stage[i] << (2**i)) : stage[i];
  end

  assign dout = stage[SH_W][W-1 -: OUT_W];

endmodule

// File: rtl/binlog_enc.sv
module binlog_enc #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_code
);
  import binlog_pkg::*;

  localparam int FRAC_W  = DATA_W - EXP_W;
  localparam int MIN_POS = norm_floor(DATA_W, EXP_W);
  localparam int BAND    = DATA_W - MIN_POS;
  localparam int POS_W   = $clog2(DATA_W);
  localparam int SH_W    = shift_bits(DATA_W - MIN_POS);

  // Stage 0: leading-one search and shift amount
  logic              lead_found;
  logic [POS_W-1:0]  lead_pos;
  logic [BAND-1:0]   lead_first;
  logic [EXP_W-1:0]  exp_s0;
  logic [SH_W-1:0]   sh_s0;

  binlog_lead_detect #(
    .DATA_W (DATA_W),
    .MIN_POS(MIN_POS),
    .POS_W  (POS_W)
  ) u_lead (
    .word (in_data),
    .found(lead_found),
    .pos  (lead_pos),
    .first(lead_first)
  );

  always_comb begin
    exp_s0 = lead_found ? EXP_W'(int'(lead_pos) - MIN_POS + 1) : '0;
    sh_s0  = SH_W'(DATA_W - int'(lead_pos));
  end

  // Stage 1 registers
  logic              s1_valid;
  logic [DATA_W-1:0] s1_data;
  logic [EXP_W-1:0]  s1_exp;
  logic [SH_W-1:0]   s1_sh;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_data <= in_data;
    s1_exp  <= exp_s0;
    s1_sh   <= sh_s0;
  end

  // Stage 1 -> 2: one shifter serves normal and subnormal words
  logic [FRAC_W-1:0] frac_s1;

  binlog_shifter #(
    .W    (DATA_W),
    .SH_W (SH_W),
    .OUT_W(FRAC_W)
  ) u_shift (
    .din (s1_data),
    .amt (s1_sh),
    .dout(frac_s1)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    out_code <= {s1_exp, frac_s1};
  end

endmodule

module binlog_enc_chk #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4,
  localparam int FRAC_W  = DATA_W - EXP_W,
  localparam int MIN_POS = DATA_W - ((1 << EXP_W) - 1),
  localparam int BAND    = DATA_W - MIN_POS
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_code,
  input logic [BAND-1:0]   lead_first
);
  localparam logic [DATA_W-1:0] SUB_LIM = DATA_W'(1) << MIN_POS;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: valid follows the input strobe two edges later
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R2: reset empties the pipeline
  a_r2_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R3: at most one leading position is flagged
  a_r3_single_lead: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lead_first));

  // R3/R5: exponent is zero exactly for words below the normal band
  a_r3_exp_zero_iff_small: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid, 2)) |->
      ((out_code[DATA_W-1 -: EXP_W] == '0) == ($past(in_data, 2) < SUB_LIM)));

  // R5: subnormal words are a plain fixed shift of the low band
  a_r5_subnormal: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid, 2) && $past(in_data, 2) < SUB_LIM) |->
      (out_code == ($past(in_data, 2) << (FRAC_W - MIN_POS))));

  // R6: zero maps to zero
  a_r6_zero: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid, 2) && $past(in_data, 2) == '0) |->
      (out_code == '0));

endmodule

bind binlog_enc binlog_enc_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/binlog_enc_tb.sv
`timescale 1ns/1ps
module binlog_enc_tb;

  localparam int BW = 32, BE = 4;
  localparam int SW = 12, SE = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic          b_iv, s_iv, b_ov, s_ov;
  logic [BW-1:0] b_in, b_out;
  logic [SW-1:0] s_in, s_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  binlog_enc #(.DATA_W(BW), .EXP_W(BE)) u_dut (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_data(b_in),
    .out_valid(b_ov), .out_code(b_out));

  binlog_enc #(.DATA_W(SW), .EXP_W(SE)) u_small (
    .clk(clk), .rst(rst), .in_valid(s_iv), .in_data(s_in),
    .out_valid(s_ov), .out_code(s_out));

  task automatic report_and_end();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report_and_end();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Arithmetic model: value = 2^p * (1 + f), f coded in the fraction field
  function automatic logic [31:0] model(input logic [31:0] x, input int dw, input int ew);
    int fw, mn, p;
    longint unsigned rem, fr;
    fw = dw - ew;
    mn = dw - (2**ew - 1);
    p  = -1;
    for (int i = 0; i < dw; i++) if (x[i]) p = i;
    if (p < mn) return 32'(longint'(x) * (64'd1 << (fw - mn)));
    rem = longint'(x) - (64'd1 << p);
    if (fw >= p) fr = rem << (fw - p);
    else         fr = rem >> (p - fw);
    return 32'((longint'(p - mn + 1) << fw) | fr);
  endfunction

  task automatic check_result(input string who, input logic [31:0] x, input logic [31:0] act,
                              input int dw, input int ew);
    logic [31:0] exp, fmask;
    int fw, mn;
    fw = dw - ew;
    mn = dw - (2**ew - 1);
    exp = model(x, dw, ew);
    fmask = (32'd1 << fw) - 1;
    if (dw == 32 && x == 32'h0700_0000) check({who, " R7 example normal"}, act, 32'hAC00_0000);
    if (dw == 32 && x == 32'h0000_8000) check({who, " R7 example subnormal"}, act, 32'h0400_0000);
    if (x == 0) check({who, " R6 zero"}, act, 32'd0);
    else if (x < (32'd1 << mn)) check({who, " R5 subnormal"}, act, exp);
    else begin
      check({who, " R3 exponent"}, act >> fw, exp >> fw);
      check({who, " R4 fraction"}, act & fmask, exp & fmask);
    end
  endtask

  function automatic logic [31:0] big_vec(input int j, inout logic [31:0] xs);
    if (j == 0) return 32'h0700_0000;
    if (j == 1) return 32'h0000_8000;
    if (j == 2) return 32'h0;
    if (j < 35) return 32'd1 << (j - 3);
    if (j < 67) return 32'hFFFF_FFFF >> (j - 35);
    xs ^= xs << 13;
    xs ^= xs >> 17;
    xs ^= xs << 5;
    return (j % 2 == 0) ? xs : (xs >> xs[4:0]);
  endfunction

  logic        hv_b[2], hv_s[2];
  logic [31:0] hd_b[2], hd_s[2];

  initial begin
    logic [31:0] xs;
    int bidx, sidx, k;
    xs = 32'h1234_5678;
    rst = 1'b1;
    b_iv = 1'b1; s_iv = 1'b1;
    b_in = 32'hDEAD_BEEF; s_in = 12'hABC;
    repeat (3) @(negedge clk);
    check("R2 reset valid big", 32'(b_ov), 32'd0);
    check("R2 reset valid small", 32'(s_ov), 32'd0);
    rst = 1'b0;
    b_iv = 1'b0; s_iv = 1'b0;
    for (int i = 0; i < 2; i++) begin
      hv_b[i] = 1'b0; hv_s[i] = 1'b0; hd_b[i] = '0; hd_s[i] = '0;
    end
    bidx = 0; sidx = 0; k = 0;
    while (sidx < 4096 || bidx < 2100 || hv_b[0] || hv_b[1] || hv_s[0] || hv_s[1]) begin
      logic v;
      @(negedge clk);
      check("R1 valid big", 32'(b_ov), 32'(hv_b[1]));
      check("R1 valid small", 32'(s_ov), 32'(hv_s[1]));
      if (hv_b[1] && b_ov) check_result("big", hd_b[1], b_out, BW, BE);
      if (hv_s[1] && s_ov) check_result("small", hd_s[1], 32'(s_out), SW, SE);
      hv_b[1] = hv_b[0]; hd_b[1] = hd_b[0];
      hv_s[1] = hv_s[0]; hd_s[1] = hd_s[0];
      v = (k % 9) != 4;
      k++;
      b_iv = v && (bidx < 2100);
      s_iv = v && (sidx < 4096);
      b_in = b_iv ? big_vec(bidx, xs) : 32'hFFFF_0000;
      s_in = s_iv ? SW'(sidx) : 12'hFFF;
      if (b_iv) bidx++;
      if (s_iv) sidx++;
      hv_b[0] = b_iv; hd_b[0] = b_in;
      hv_s[0] = s_iv; hd_s[0] = 32'(s_in);
    end
    report_and_end();
  end

endmodule